// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block is the interrupt and fill-level logic placed beside the transmit and receive FIFOs of a serial controller. It does not hold data. It follows the FIFOs through their push and pop strobes and keeps an entry count for each side. It compares those counts with two programmable thresholds and turns the results, together with overflow and underflow events, into five interrupt sources. These sources pass through a mask and are combined into one interrupt line.

Software programs the thresholds, the mask and the error-clear action through a small write port. The levels, thresholds, mask, raw status and masked status are all visible on output ports. A threshold register only accepts a value below the FIFO depth. Software can therefore find the depth by writing rising values until the readback no longer matches. The receive threshold is held as the wanted level minus one. Taking the controller enable low empties both level counters and clears every error flag.

Top module: `fic_irq_ctrl`

## Requirements
- R1: After reset both levels are 0, both thresholds are 0, the mask is 0, all error flags are 0 and `irq` is low. The raw status is therefore 5'b00001, with only the transmit-empty bit set.
- R2: While enabled, a push strobe raises that side's level by one and a pop strobe lowers it by one. Push and pop together leave the level unchanged. A transmit pop at level 0 has no effect. Each change appears one clock after the strobe.
- R3: A push at level DEPTH is dropped, and a pop in the same cycle is still taken. The push sets the overflow flag, which is raw bit 1 for the transmit side and raw bit 3 for the receive side.
- R4: A receive pop at level 0 leaves the level at 0 and sets the receive-underflow flag (raw bit 3'd2). A push in the same cycle is still taken.
- R5: Raw bit 0 (transmit-empty) is 1 exactly while the transmit level is at or below the transmit threshold. It follows the level on every cycle and is never held.
- R6: Raw bit 4 (receive-full) is 1 exactly while the receive level is strictly above the receive threshold. It follows the level on every cycle.
- R7: A threshold write is addressed with `cfg_addr` 0 for transmit and 1 for receive. A value below DEPTH is stored. A value of DEPTH or more is discarded and the old value is kept, so a depth probe first fails at DEPTH.
- R8: The error flags (raw bits 1 to 3) stay set until a write to `cfg_addr` 3, which clears each flag whose `cfg_wdata` bit at the same position is 1. If a flag is set and cleared in the same cycle, it ends up set.
- R9: A write to `cfg_addr` 2 loads the mask from `cfg_wdata[4:0]`. `irq_stat` is raw status ANDed with the mask. `irq` is high exactly when any `irq_stat` bit is 1.
- R10: While `ctrl_en` is low, both levels are forced to 0, the error flags are cleared and strobes are ignored. The thresholds and the mask keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable; low flushes the levels and the error flags |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_pop | input | 1 | Transmit FIFO read strobe from the serial engine |
| rx_push | input | 1 | Receive FIFO write strobe from the serial engine |
| rx_pop | input | 1 | Receive FIFO read strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | 0 transmit threshold, 1 receive threshold, 2 mask, 3 error clear |
| cfg_wdata | input | WDATA_W | Configuration write data |
| tx_level | output | CNT_W | Transmit FIFO entry count |
| rx_level | output | CNT_W | Receive FIFO entry count |
| tx_thr | output | THR_W | Transmit threshold readback |
| rx_thr | output | THR_W | Receive threshold readback (wanted level minus one) |
| irq_mask | output | 5 | Mask readback |
| raw_stat | output | 5 | Raw status: bit0 transmit-empty, bit1 transmit-overflow, bit2 receive-underflow, bit3 receive-overflow, bit4 receive-full |
| irq_stat | output | 5 | Masked status |
| irq | output | 1 | Interrupt request |

## Verification
A level counter that drifts by one stays wrong until the next flush. It shows up on the level ports one clock after the bad strobe, and later as a transmit-empty or receive-full bit that flips one entry early or late. A lost or stuck error flag appears on `raw_stat` in the cycle after the event or after the clear, and it is visible on `irq` only when that source is unmasked. A threshold register that takes an out-of-range value shows at once on readback, and the depth probe then reports the wrong depth.

// File: rtl/fic_pkg.sv
package fic_pkg;

  localparam int SRC_N = 5;

  // Status bit positions (software decodes these)
  localparam int BIT_TX_EMPTY = 0;
  localparam int BIT_TX_OVF   = 1;
  localparam int BIT_RX_UNF   = 2;
  localparam int BIT_RX_OVF   = 3;
  localparam int BIT_RX_FULL  = 4;

  // Bits that hold until cleared; the others track levels live
  localparam logic [SRC_N-1:0] STICKY_MAP = 5'b01110;

  typedef enum logic [1:0] {
    CFG_TX_THR  = 2'd0,
    CFG_RX_THR  = 2'd1,
    CFG_MASK    = 2'd2,
    CFG_ERR_CLR = 2'd3
  } cfg_addr_e;

  // Next occupancy given accepted push and pop
  function automatic logic [31:0] next_level(logic [31:0] lvl, logic inc, logic dec);
    return lvl + {31'd0, inc} - {31'd0, dec};
  endfunction

  // A threshold value is kept only when below the depth
  function automatic logic thr_fits(logic [31:0] val, logic [31:0] depth);
    return val < depth;
  endfunction

  // Transmit side asks for data while at or below its mark
  function automatic logic at_or_below(logic [31:0] lvl, logic [31:0] thr);
    return lvl <= thr;
  endfunction

  // Receive side reports once it passes its mark
  function automatic logic above(logic [31:0] lvl, logic [31:0] thr);
    return lvl > thr;
  endfunction

endpackage

// File: rtl/fic_level_track.sv
module fic_level_track #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] level,
  output logic             ovf_evt
);
  import fic_pkg::*;

  logic [CNT_W-1:0] level_q, level_d;
  logic full, empty, push_ok, pop_ok;

  assign full    = (level_q == CNT_W'(DEPTH));
  assign empty   = (level_q == '0);
  assign push_ok = en & push & ~full;
  assign pop_ok  = en & pop & ~empty;
  assign ovf_evt = en & push & full;

  always_comb begin
    if (!en) level_d = '0;
    else     level_d = CNT_W'(next_level(32'(level_q), push_ok, pop_ok));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign level = level_q;

  // R2
  level_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && push && !pop && !full) |=> (level_q == $past(level_q) + CNT_W'(1)));

  // R3
  push_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && push && !pop && full) |=> (level_q == CNT_W'(DEPTH)));

  // R10
  dis_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (level_q == '0));

endmodule

// File: rtl/fic_thr_reg.sv
module fic_thr_reg #(
  parameter int DEPTH   = 8,
  parameter int THR_W   = $clog2(DEPTH),
  parameter int WDATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [WDATA_W-1:0] wdata,
  output logic [THR_W-1:0]   thr
);
  import fic_pkg::*;

  logic fits, take;
  logic [THR_W-1:0] thr_q;

  assign fits = thr_fits(32'(wdata), 32'(DEPTH));
  assign take = we & fits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    thr_q <= '0;
    else if (take) thr_q <= THR_W'(wdata);
  end

  assign thr = thr_q;

  // R7
  thr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !fits) |=> $stable(thr_q));

  // R7
  thr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && fits) |=> (32'(thr_q) == 32'($past(wdata))));

endmodule

// File: rtl/fic_irq_status.sv
module fic_irq_status #(
  parameter int SRC_N = fic_pkg::SRC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SRC_N-1:0] src_cond,
  input  logic             clr_we,
  input  logic [SRC_N-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [SRC_N-1:0] mask_wdata,
  output logic [SRC_N-1:0] raw,
  output logic [SRC_N-1:0] masked,
  output logic [SRC_N-1:0] mask,
  output logic             irq
);
  import fic_pkg::*;

  logic [SRC_N-1:0] mask_q;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    if (STICKY_MAP[i]) begin : g_sticky
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     flag_q <= 1'b0;
        else if (!en)                   flag_q <= 1'b0;
        else if (src_cond[i])           flag_q <= 1'b1;
        else if (clr_we && clr_bits[i]) flag_q <= 1'b0;
      end
      assign raw[i] = flag_q;

      // R8
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && flag_q && !(clr_we && clr_bits[i])) |=> flag_q);

      // R8
      sticky_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(src_cond[i]));
    end else begin : g_live
      assign raw[i] = src_cond[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign mask   = mask_q;
  assign masked = raw & mask_q;
  assign irq    = |masked;

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw != '0));

endmodule

// File: rtl/fic_irq_ctrl.sv
module fic_irq_ctrl #(
  parameter int DEPTH   = 8,
  parameter int WDATA_W = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int THR_W  = $clog2(DEPTH),
  localparam int SRC_N  = fic_pkg::SRC_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_en,
  input  logic               tx_push,
  input  logic               tx_pop,
  input  logic               rx_push,
  input  logic               rx_pop,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [WDATA_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0]   tx_level,
  output logic [CNT_W-1:0]   rx_level,
  output logic [THR_W-1:0]   tx_thr,
  output logic [THR_W-1:0]   rx_thr,
  output logic [SRC_N-1:0]   irq_mask,
  output logic [SRC_N-1:0]   raw_stat,
  output logic [SRC_N-1:0]   irq_stat,
  output logic               irq
);
  import fic_pkg::*;

  cfg_addr_e sel;
  logic we_tx_thr, we_rx_thr, we_mask, we_clr;
  logic tx_ovf_evt, rx_ovf_evt, rx_unf_evt;
  logic tx_low, rx_high;
  logic [SRC_N-1:0] src_cond;

  assign sel       = cfg_addr_e'(cfg_addr);
  assign we_tx_thr = cfg_we && (sel == CFG_TX_THR);
  assign we_rx_thr = cfg_we && (sel == CFG_RX_THR);
  assign we_mask   = cfg_we && (sel == CFG_MASK);
  assign we_clr    = cfg_we && (sel == CFG_ERR_CLR);

  fic_level_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_lvl (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .push(tx_push), .pop(tx_pop),
    .level(tx_level), .ovf_evt(tx_ovf_evt));

  fic_level_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_lvl (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .push(rx_push), .pop(rx_pop),
    .level(rx_level), .ovf_evt(rx_ovf_evt));

  fic_thr_reg #(.DEPTH(DEPTH), .THR_W(THR_W), .WDATA_W(WDATA_W)) u_tx_thr (
    .clk(clk), .rst_n(rst_n), .we(we_tx_thr), .wdata(cfg_wdata), .thr(tx_thr));

  fic_thr_reg #(.DEPTH(DEPTH), .THR_W(THR_W), .WDATA_W(WDATA_W)) u_rx_thr (
    .clk(clk), .rst_n(rst_n), .we(we_rx_thr), .wdata(cfg_wdata), .thr(rx_thr));

  // Receive underflow: a read attempt with nothing stored
  assign rx_unf_evt = ctrl_en & rx_pop & (rx_level == '0);

  assign tx_low  = at_or_below(32'(tx_level), 32'(tx_thr));
  assign rx_high = above(32'(rx_level), 32'(rx_thr));

  always_comb begin
    src_cond               = '0;
    src_cond[BIT_TX_EMPTY] = tx_low;
    src_cond[BIT_TX_OVF]   = tx_ovf_evt;
    src_cond[BIT_RX_UNF]   = rx_unf_evt;
    src_cond[BIT_RX_OVF]   = rx_ovf_evt;
    src_cond[BIT_RX_FULL]  = rx_high;
  end

  fic_irq_status #(.SRC_N(SRC_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .src_cond(src_cond),
    .clr_we(we_clr), .clr_bits(cfg_wdata[SRC_N-1:0]),
    .mask_we(we_mask), .mask_wdata(cfg_wdata[SRC_N-1:0]),
    .raw(raw_stat), .masked(irq_stat), .mask(irq_mask), .irq(irq));

  // R10
  dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (raw_stat[BIT_RX_OVF:BIT_TX_OVF] == '0 && rx_level == '0));

  // R4
  unf_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_unf_evt && !rx_push) |=> (rx_level == '0 && raw_stat[BIT_RX_UNF]));

endmodule

// File: tb/tb_fic_irq_ctrl.sv
`timescale 1ns/1ps
module tb_fic_irq_ctrl;
  localparam int DEPTH = 8;
  localparam int WDATA_W = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int THR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_en = 1'b0;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [WDATA_W-1:0] cfg_wdata = '0;
  logic [CNT_W-1:0] tx_level, rx_level;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [4:0] irq_mask, raw_stat, irq_stat;
  logic irq;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fic_irq_ctrl #(.DEPTH(DEPTH), .WDATA_W(WDATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
    .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_level(tx_level), .rx_level(rx_level), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .irq_mask(irq_mask), .raw_stat(raw_stat), .irq_stat(irq_stat), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Inputs change 1 ns after a rising edge, so they are stable around each edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic strobe(logic tp, logic tq, logic rp, logic rq);
    tx_push = tp; tx_pop = tq; rx_push = rp; rx_pop = rq;
    step();
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
  endtask

  task automatic cfg_write(logic [1:0] a, logic [WDATA_W-1:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 0;
  endtask

  task automatic flush();
    ctrl_en = 0; step(); ctrl_en = 1; step();
  endtask

  task automatic t_reset();
    check("R1 tx_level", 32'(tx_level), 0);
    check("R1 rx_level", 32'(rx_level), 0);
    check("R1 thresholds", {16'(tx_thr), 16'(rx_thr)}, 0);
    check("R1 mask", 32'(irq_mask), 0);
    check("R1 raw", 32'(raw_stat), 32'h01);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_levels();
    flush();
    for (int i = 0; i < 3; i++) strobe(1, 0, 0, 0);
    check("R2 tx push x3", 32'(tx_level), 3);
    strobe(1, 1, 0, 0);
    check("R2 tx push+pop", 32'(tx_level), 3);
    strobe(0, 1, 0, 0);
    check("R2 tx pop", 32'(tx_level), 2);
    for (int i = 0; i < 3; i++) strobe(0, 1, 0, 0);
    check("R2 tx pop at empty", 32'(tx_level), 0);
    strobe(0, 0, 1, 0); strobe(0, 0, 1, 0);
    check("R2 rx push x2", 32'(rx_level), 2);
  endtask

  task automatic t_overflow();
    flush();
    for (int i = 0; i < DEPTH; i++) strobe(1, 0, 1, 0);
    check("R3 full tx", 32'(tx_level), DEPTH);
    check("R3 no ovf yet", 32'(raw_stat[3:1]), 0);
    strobe(1, 0, 0, 0);
    check("R3 tx push at full level", 32'(tx_level), DEPTH);
    check("R3 tx ovf bit1", 32'(raw_stat[1]), 1);
    check("R3 rx ovf bit3 clear", 32'(raw_stat[3]), 0);
    strobe(0, 0, 1, 1);
    check("R3 rx push+pop at full", 32'(rx_level), DEPTH - 1);
    check("R3 rx ovf bit3", 32'(raw_stat[3]), 1);
  endtask

  task automatic t_underflow();
    flush();
    strobe(0, 0, 0, 1);
    check("R4 rx level stays 0", 32'(rx_level), 0);
    check("R4 unf bit2", 32'(raw_stat[2]), 1);
    flush();
    strobe(0, 0, 1, 1);
    check("R4 push+pop at empty", 32'(rx_level), 1);
    check("R4 unf bit2 with push", 32'(raw_stat[2]), 1);
  endtask

  task automatic t_thresh();
    flush();
    cfg_write(2'd0, 16'd2);
    check("R5 tx level 0 at/below 2", 32'(raw_stat[0]), 1);
    for (int i = 0; i < 3; i++) strobe(1, 0, 0, 0);
    check("R5 tx level 3 above 2", 32'(raw_stat[0]), 0);
    strobe(0, 1, 0, 0);
    check("R5 tx level 2 equal", 32'(raw_stat[0]), 1);
    cfg_write(2'd1, 16'd3);
    for (int i = 0; i < 3; i++) strobe(0, 0, 1, 0);
    check("R6 rx level 3 not above 3", 32'(raw_stat[4]), 0);
    strobe(0, 0, 1, 0);
    check("R6 rx level 4 above 3", 32'(raw_stat[4]), 1);
    strobe(0, 0, 0, 1);
    check("R6 rx drops back", 32'(raw_stat[4]), 0);
  endtask

  task automatic t_probe();
    int found = 0;
    for (int v = 1; v < 300; v++) begin
      cfg_write(2'd0, 16'(v));
      if (32'(tx_thr) != 32'(v)) begin
        found = v;
        break;
      end
    end
    check("R7 probed depth", 32'(found), DEPTH);
    check("R7 tx thr kept", 32'(tx_thr), DEPTH - 1);
    cfg_write(2'd1, 16'd5);
    cfg_write(2'd1, 16'h0100);
    check("R7 rx thr kept", 32'(rx_thr), 5);
  endtask

  task automatic t_sticky();
    flush();
    for (int i = 0; i <= DEPTH; i++) strobe(1, 0, 0, 0);
    step(); step();
    check("R8 ovf held", 32'(raw_stat[1]), 1);
    cfg_write(2'd3, 16'h0008);
    check("R8 other bit clear no effect", 32'(raw_stat[1]), 1);
    cfg_write(2'd3, 16'h0002);
    check("R8 cleared", 32'(raw_stat[1]), 0);
    tx_push = 1; cfg_we = 1; cfg_addr = 2'd3; cfg_wdata = 16'h0002;
    step();
    tx_push = 0; cfg_we = 0;
    check("R8 set beats clear", 32'(raw_stat[1]), 1);
  endtask

  task automatic t_mask();
    flush();
    cfg_write(2'd0, 16'd0);
    cfg_write(2'd1, 16'd0);
    cfg_write(2'd2, 16'h0000);
    check("R9 masked off", 32'(irq), 0);
    cfg_write(2'd2, 16'h0001);
    check("R9 mask readback", 32'(irq_mask), 1);
    check("R9 irq_stat", 32'(irq_stat), 1);
    check("R9 irq on", 32'(irq), 1);
    cfg_write(2'd2, 16'h0010);
    check("R9 rx_full masked in but idle", 32'(irq), 0);
    strobe(0, 0, 1, 0);
    check("R9 rx_full raises irq", {31'd0, irq}, 1);
    check("R9 irq_stat rx_full", 32'(irq_stat), 32'h10);
  endtask

  task automatic t_disable();
    flush();
    cfg_write(2'd0, 16'd3);
    cfg_write(2'd2, 16'h000A);
    for (int i = 0; i <= DEPTH; i++) strobe(1, 0, 1, 0);
    check("R10 pre flags", 32'(raw_stat[3:1]), 32'h5);
    ctrl_en = 0;
    strobe(1, 0, 1, 0);
    check("R10 tx zero", 32'(tx_level), 0);
    check("R10 rx zero", 32'(rx_level), 0);
    check("R10 flags clear", 32'(raw_stat[3:1]), 0);
    strobe(1, 0, 0, 1);
    check("R10 strobes ignored", {16'(tx_level), 16'(raw_stat)}, 32'h1);
    check("R10 thr kept", 32'(tx_thr), 3);
    check("R10 mask kept", 32'(irq_mask), 32'h0A);
    ctrl_en = 1;
    step();
  endtask

  initial begin
    #(8 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    ctrl_en = 1;
    step();
    t_levels();
    t_overflow();
    t_underflow();
    t_thresh();
    t_probe();
    t_sticky();
    t_mask();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule